// File: doc/BRIEF.md
# Serial-Loaded Configuration Register Bank

This block holds fourteen 8-bit configuration registers. A serial control port loads them one byte at a time. A slave front end sits ahead of the block and has already turned the bus traffic into a byte stream. Each frame on that stream has three parts: a frame-open strobe, one or more bytes sent with a valid/ready handshake, and a frame-close strobe. The first byte of a frame is a subaddress. The bytes after it go to one register, or, when the subaddress carries the burst code, to the whole bank in index order. All register contents are driven out in parallel to the datapath they configure.

The byte input follows valid/ready rules. A byte is accepted on every clock edge where `cb_valid` and `cb_ready` are both high. The block never applies back-pressure: `cb_ready` is high whenever reset is released, so a producer can send one byte per cycle. After each accepted data byte that changes a register, the block raises a one-cycle write pulse and reports the index of that register.

Top module: `cfgbank_top`

## Requirements
- R1: In the first accepted byte of a frame, bits 3..0 choose a register index, bit 4 is the burst-mode bit, and bits 7..5 have no effect.
- R2: When bit 4 of the subaddress is 0 and the index is 0..13, the next accepted byte is written into that register.
- R3: A subaddress whose low five bits are 1_1111 starts a burst. The following accepted bytes are written to indices 0, 1, 2, … up to 13, one byte per index.
- R4: The registers are ordered red offset, coarse and fine (indices 0–2), then green (3–5), then blue (6–8). Reset sets each offset register to 0x7F and each coarse register to 0x20. Reset clears each fine register.
- R5: Reset sets control (index 9) to 0x04, VCO (index 10) to 0x61 and divider (index 11) to 0x90. Reset clears phase A (12) and phase B (13).
- R6: The fine registers (2, 5, 8) keep only bits 4..0, and the phase registers (12, 13) keep only bits 6..0. All other bits of these registers read 0.
- R7: In a single-register frame, every data byte after the first one is ignored.
- R8: In a burst, bytes that arrive after index 13 has been written are ignored. If a burst frame ends early, the registers it did not reach keep their values.
- R9: These subaddresses discard every data byte of the frame and produce no write pulse:
  - bit 4 = 0 with index 14 or 15;
  - bit 4 = 1 with low bits other than 1_1111.
- R10: A register takes its new value on the clock edge that accepts its byte. On the cycle after that edge, `wr_pulse` is high for one cycle and `wr_index` gives the register index.
- R11: `cb_ready` is high whenever reset is released. A byte accepted outside a frame (before any frame-open strobe, or after a frame-close strobe) has no effect. A byte accepted in the same cycle as the frame-open strobe has no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_open | input | 1 | Frame-open strobe |
| frm_close | input | 1 | Frame-close strobe |
| cb_valid | input | 1 | Byte valid |
| cb_ready | output | 1 | Byte ready (never deasserted out of reset) |
| cb_data | input | 8 | Byte value |
| bank_q | output | 112 | All registers; register i at bits [8i+7:8i] |
| wr_pulse | output | 1 | One-cycle pulse after a register write |
| wr_index | output | 4 | Index of the register just written |

## Verification
The bench sends bursts that overrun the bank. A design without a stop at index 13 would wrap around and overwrite the offset registers, or would write to a register that does not exist. The bench sends a burst that is cut short, which catches a design that fills the rest of the bank. It sends subaddresses with junk in bits 7..5 and with a mode-1 code that is not the burst code. A decoder that compares the full byte, or treats any mode-1 byte as a burst, fails these cases. It also writes all-ones into the fine and phase registers and sends bytes outside any frame. Missing bit masks show up as extra high bits, and a missing frame gate shows up as stray writes.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int unsigned NREG = 14;
  localparam int unsigned DW   = 8;
  localparam int unsigned SELW = 4;
  localparam logic [4:0]  BURST_CODE = 5'h1F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SUB, ST_SINGLE, ST_BURST, ST_DROP
  } seq_state_e;

  function automatic logic [DW-1:0] reg_reset(input int unsigned idx);
    if (idx < 9) begin
      case (idx % 3)
        0:       return 8'h7F;
        1:       return 8'h20;
        default: return 8'h00;
      endcase
    end
    case (idx)
      9:       return 8'h04;
      10:      return 8'h61;
      11:      return 8'h90;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_mask(input int unsigned idx);
    if (idx < 9 && (idx % 3) == 2) return 8'h1F;
    if (idx == 12 || idx == 13)    return 8'h7F;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/cfgbank_seq.sv
module cfgbank_seq
  import cfgbank_pkg::*;
#(
  parameter int unsigned N_REGS = NREG,
  parameter int unsigned BW     = DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_open,
  input  logic            frm_close,
  input  logic            take,
  input  logic [BW-1:0]   byte_in,
  output logic            wr_en,
  output logic [SELW-1:0] wr_sel
);
  localparam logic [SELW-1:0] LAST = SELW'(N_REGS - 1);

  seq_state_e      st;
  logic [SELW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      ptr <= '0;
    end else if (frm_open) begin
      st <= ST_SUB;
    end else begin
      case (st)
        ST_SUB: if (take) begin
          if (byte_in[4:0] == BURST_CODE) begin
            st  <= ST_BURST;
            ptr <= '0;
          end else if (!byte_in[4] && (32'(byte_in[3:0]) < N_REGS)) begin
            st  <= ST_SINGLE;
            ptr <= byte_in[3:0];
          end else begin
            st <= ST_DROP;
          end
        end
        ST_SINGLE: if (take) st <= ST_DROP;
        ST_BURST: if (take) begin
          if (ptr == LAST) st <= ST_DROP;
          else             ptr <= ptr + 1'b1;
        end
        default: ;
      endcase
      if (frm_close) st <= ST_IDLE;
    end
  end

  always_comb begin
    wr_en  = take && !frm_open && (st == ST_SINGLE || st == ST_BURST);
    wr_sel = ptr;
  end
endmodule

// File: rtl/cfgbank_regfile.sv
module cfgbank_regfile
  import cfgbank_pkg::*;
#(
  parameter int unsigned N_REGS = NREG,
  parameter int unsigned BW     = DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SELW-1:0]    wr_sel,
  input  logic [BW-1:0]      wr_data,
  output logic [N_REGS*BW-1:0] q_flat
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    localparam logic [BW-1:0] RV = BW'(reg_reset(i));
    localparam logic [BW-1:0] MK = BW'(reg_mask(i));
    logic [BW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    q <= RV;
      else if (wr_en && wr_sel == SELW'(i))          q <= wr_data & MK;
    end
    assign q_flat[i*BW +: BW] = q;
  end
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_open,
  input  logic              frm_close,
  input  logic              cb_valid,
  output logic              cb_ready,
  input  logic [DW-1:0]     cb_data,
  output logic [NREG*DW-1:0] bank_q,
  output logic              wr_pulse,
  output logic [SELW-1:0]   wr_index
);
  logic            take;
  logic            wr_en;
  logic [SELW-1:0] wr_sel;

  assign cb_ready = rst_n;
  assign take     = cb_valid && cb_ready;

  cfgbank_seq #(.N_REGS(NREG), .BW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .frm_open(frm_open), .frm_close(frm_close),
    .take(take), .byte_in(cb_data), .wr_en(wr_en), .wr_sel(wr_sel)
  );

  cfgbank_regfile #(.N_REGS(NREG), .BW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(cb_data), .q_flat(bank_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      wr_index <= '0;
    end else begin
      wr_pulse <= wr_en;
      wr_index <= wr_sel;
    end
  end
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
  import cfgbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cb_valid,
  input logic              cb_ready,
  input logic [NREG*DW-1:0] bank_q,
  input logic              wr_pulse,
  input logic [SELW-1:0]   wr_index
);
  a_r6_fine_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q[2*DW+5 +: 3] == 3'b0) && (bank_q[5*DW+5 +: 3] == 3'b0) &&
    (bank_q[8*DW+5 +: 3] == 3'b0));

  a_r6_phase_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_q[12*DW+7] && !bank_q[13*DW+7]);

  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(cb_valid));

  a_r10_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> (32'(wr_index) < NREG));

  a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cb_valid |=> $stable(bank_q));

  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cb_ready);
endmodule

bind cfgbank_top cfgbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cb_valid(cb_valid), .cb_ready(cb_ready),
  .bank_q(bank_q), .wr_pulse(wr_pulse), .wr_index(wr_index)
);

// File: tb/cfgbank_top_test.sv
`timescale 1ns/1ps
module cfgbank_top_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         frm_open, frm_close, cb_valid, cb_ready;
  logic [7:0]   cb_data;
  logic [111:0] bank_q;
  logic         wr_pulse;
  logic [3:0]   wr_index;

  int checks = 0, failures = 0;
  int pulses;
  int last_idx;
  logic [7:0] exp_q [14];

  always #2.5 clk = ~clk;

  cfgbank_top uut (
    .clk(clk), .rst_n(rst_n), .frm_open(frm_open), .frm_close(frm_close),
    .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_data(cb_data),
    .bank_q(bank_q), .wr_pulse(wr_pulse), .wr_index(wr_index)
  );

  function automatic logic [7:0] bmask(input int i);
    if (i == 2 || i == 5 || i == 8) return 8'h1F;
    if (i == 12 || i == 13)         return 8'h7F;
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < 14; i++)
      chk($sformatf("%s reg%0d", req, i), int'(bank_q[i*8 +: 8]), int'(exp_q[i]));
  endtask

  task automatic put_byte(input logic [7:0] d);
    cb_valid = 1'b1; cb_data = d;
    @(negedge clk);
    cb_valid = 1'b0;
    if (wr_pulse) begin pulses++; last_idx = int'(wr_index); end
  endtask

  task automatic open_frame(input logic [7:0] sub);
    pulses = 0; last_idx = -1;
    frm_open = 1'b1; @(negedge clk); frm_open = 1'b0;
    put_byte(sub);
  endtask

  task automatic close_frame();
    frm_close = 1'b1; @(negedge clk); frm_close = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    exp_q = '{8'h7F,8'h20,8'h00, 8'h7F,8'h20,8'h00, 8'h7F,8'h20,8'h00,
              8'h04,8'h61,8'h90,8'h00,8'h00};
    chk_bank("R4/R5 reset");
    chk("R11 ready", int'(cb_ready), 1);
    chk("R10 no pulse at reset", int'(wr_pulse), 0);
  endtask

  task automatic t_single();
    open_frame(8'h04); put_byte(8'hA5);
    chk("R10 pulse", pulses, 1); chk("R10 index", last_idx, 4);
    close_frame();
    exp_q[4] = 8'hA5; chk_bank("R2 single");
  endtask

  task automatic t_single_extra();
    open_frame(8'h01); put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
    chk("R7 one pulse", pulses, 1);
    close_frame();
    exp_q[1] = 8'h11; chk_bank("R7 extra ignored");
  endtask

  task automatic t_upper_bits();
    open_frame(8'hE3); put_byte(8'h3C); close_frame();
    exp_q[3] = 8'h3C; chk_bank("R1 bits7..5 ignored");
  endtask

  task automatic t_masks();
    open_frame(8'h02); put_byte(8'hFF); close_frame();
    open_frame(8'h0C); put_byte(8'hFF); close_frame();
    exp_q[2] = 8'h1F; exp_q[12] = 8'h7F; chk_bank("R6 masks");
  endtask

  task automatic t_invalid();
    open_frame(8'h0E); put_byte(8'h55); put_byte(8'h56);
    chk("R9 idx14 no pulse", pulses, 0); close_frame();
    open_frame(8'h0F); put_byte(8'h57);
    chk("R9 idx15 no pulse", pulses, 0); close_frame();
    open_frame(8'h13); put_byte(8'h58); put_byte(8'h59);
    chk("R9 mode1 no pulse", pulses, 0); close_frame();
    chk_bank("R9 discard");
  endtask

  task automatic t_burst_full();
    open_frame(8'hFF);
    for (int k = 0; k < 16; k++) put_byte(8'hC0 + 8'(k));
    chk("R3 burst pulses", pulses, 14); chk("R8 last index", last_idx, 13);
    close_frame();
    for (int i = 0; i < 14; i++) exp_q[i] = (8'hC0 + 8'(i)) & bmask(i);
    chk_bank("R3/R8 burst full");
  endtask

  task automatic t_burst_short();
    open_frame(8'h1F);
    for (int k = 0; k < 5; k++) put_byte(8'h10 + 8'(k));
    chk("R8 short pulses", pulses, 5);
    close_frame();
    for (int i = 0; i < 5; i++) exp_q[i] = (8'h10 + 8'(i)) & bmask(i);
    chk_bank("R8 short burst");
  endtask

  task automatic t_outside();
    pulses = 0;
    put_byte(8'h42); put_byte(8'h07);
    chk("R11 outside no pulse", pulses, 0);
    frm_open = 1'b1; cb_valid = 1'b1; cb_data = 8'h05;
    @(negedge clk); frm_open = 1'b0; cb_valid = 1'b0;
    put_byte(8'h66); put_byte(8'h77); close_frame();
    exp_q[6] = 8'h77 & 8'hFF;
    exp_q[6] = exp_q[6];
    chk_bank("R11 outside/open-cycle byte");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_open = 0; frm_close = 0; cb_valid = 0; cb_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_single_extra();
    t_upper_bits();
    t_masks();
    t_invalid();
    t_burst_full();
    t_burst_short();
    // R11: the byte in the open cycle is dropped, 0x66 becomes the
    // subaddress (idx 6), 0x77 lands in register 6.
    t_outside();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule